// File: doc/BRIEF.md
# Masked-Configuration GPIO Bank

This block is one bank of general-purpose I/O lines behind a small 32-bit register port. Every line carries a configuration word: a peripheral function number, a direction, pull-up and pull-down enables, slew, input filter controls, open-drain, Schmitt input, a two-bit drive strength and an event-select field. Software does not reach these words one by one. It first writes a line-select mask, and a single write to the shared configuration address then lands in every line whose mask bit is set. A read of the configuration address returns the word of the lowest-numbered selected line.

The output latch is changed only through a set-bits address and a clear-bits address, so several lines can be moved in one write without a read-modify-write. A separate status address reads the latch back. Pin levels arrive through a two-flop synchronizer and are visible at the pin-status address. On the pad side, each line gets its output value, its output enable and the configuration fields a pad cell needs. A line owned by a peripheral function gets no drive from this bank. Banks sit 0x40 bytes apart, so the block decodes a 6-bit byte offset.

Top module: `gpio_bank_regs`

## Requirements
- R1: After a synchronous reset, every register (mask, all configurations, output latch, synchronizer) is zero, so every readable offset returns 0 and pad_oe is all zero.
- R2: A write to offset 0x00 stores the full 32-bit line-select mask, and a read of 0x00 returns it.
- R3: A write to offset 0x04 replaces the configuration of exactly the lines whose mask bit is 1. All other lines keep their configuration, and with an empty mask nothing changes.
- R4: A read of 0x04 returns the configuration of the lowest-numbered line selected by the mask, or 0 when the mask is empty. The field positions are: function [2:0], direction bit 8 (1 = output), pull-up bit 9, pull-down bit 10, slew bit 11, filter enable bit 12, filter slow-clock bit 13, open-drain bit 14, Schmitt bit 15, drive [17:16], event select [26:24]. All other bits read 0.
- R5: A write to 0x10 sets each latch bit whose data bit is 1. Data bits that are 0 leave their latch bit unchanged.
- R6: A write to 0x14 clears each latch bit whose data bit is 1. Data bits that are 0 leave their latch bit unchanged.
- R7: A read of 0x18 returns the output latch.
- R8: A read of 0x08 returns pad_in as it was two rising clock edges earlier. A change on pad_in is not visible after only one edge.
- R9: A line with function 0 and open-drain 0 has pad_oe equal to its direction bit and pad_out equal to its latch bit.
- R10: A line with function 0 and open-drain 1 has pad_out 0, and pad_oe equal to direction AND NOT latch.
- R11: A line with a nonzero function has pad_oe 0 and pad_out 0.
- R12: The per-line pad fields (function, pulls, slew, filter enable and slow select, open-drain, Schmitt, drive) equal that line's stored configuration. The drive strength resets to 0.
- R13: Reads of 0x0C, 0x10, 0x14, any offset from 0x1C up, and any offset whose two low bits are not 0 return 0. Writes to 0x08, 0x0C, 0x18 or an unmapped offset change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_en | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | ADDR_W (6) | Byte offset inside the bank |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pad_in | input | NUM_LINES | Raw pin levels |
| pad_out | output | NUM_LINES | Output value per line |
| pad_oe | output | NUM_LINES | Output enable per line |
| pad_func | output | NUM_LINES x 3 | Function number per line |
| pad_pull_up | output | NUM_LINES | Pull-up enable |
| pad_pull_dn | output | NUM_LINES | Pull-down enable |
| pad_slew | output | NUM_LINES | Slew control |
| pad_filt_en | output | NUM_LINES | Input filter enable |
| pad_filt_slow | output | NUM_LINES | Filter slow-clock select |
| pad_open_drain | output | NUM_LINES | Open-drain mode |
| pad_schmitt | output | NUM_LINES | Schmitt input enable |
| pad_drive | output | NUM_LINES x 2 | Drive strength |

## Verification
The bench builds the bank with its default 32 lines, a 6-bit offset and a two-stage synchronizer. This is small enough to visit every line on its own: a distinct configuration is written into every line through a one-hot mask and read back through both the bus and the pad fields. Every combination of function number, direction, open-drain and latch value is swept on one line. Multi-bit masks then show that writes reach only the selected lines and that readback picks the lowest one. The one-edge and two-edge views of the synchronizer and every unmapped offset are checked as well.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    // word index (byte offset / 4) of each register in the bank window
    localparam logic [3:0] WA_MASK = 4'd0;
    localparam logic [3:0] WA_CFG  = 4'd1;
    localparam logic [3:0] WA_PINS = 4'd2;
    localparam logic [3:0] WA_LOCK = 4'd3;
    localparam logic [3:0] WA_SET  = 4'd4;
    localparam logic [3:0] WA_CLR  = 4'd5;
    localparam logic [3:0] WA_OUTS = 4'd6;

    localparam int BUS_W = 32;

    typedef struct packed {
        logic [2:0] evt;
        logic [1:0] drive;
        logic       schmitt;
        logic       open_drain;
        logic       filt_slow;
        logic       filt_en;
        logic       slew;
        logic       pull_dn;
        logic       pull_up;
        logic       dir;
        logic [2:0] func;
    } line_cfg_t;

    function automatic line_cfg_t cfg_from_word(input logic [BUS_W-1:0] w);
        line_cfg_t c;
        c.func       = w[2:0];
        c.dir        = w[8];
        c.pull_up    = w[9];
        c.pull_dn    = w[10];
        c.slew       = w[11];
        c.filt_en    = w[12];
        c.filt_slow  = w[13];
        c.open_drain = w[14];
        c.schmitt    = w[15];
        c.drive      = w[17:16];
        c.evt        = w[26:24];
        return c;
    endfunction

    function automatic logic [BUS_W-1:0] cfg_to_word(input line_cfg_t c);
        logic [BUS_W-1:0] w;
        w        = '0;
        w[2:0]   = c.func;
        w[8]     = c.dir;
        w[9]     = c.pull_up;
        w[10]    = c.pull_dn;
        w[11]    = c.slew;
        w[12]    = c.filt_en;
        w[13]    = c.filt_slow;
        w[14]    = c.open_drain;
        w[15]    = c.schmitt;
        w[17:16] = c.drive;
        w[26:24] = c.evt;
        return w;
    endfunction

endpackage

// File: rtl/gpio_cfg_store.sv
module gpio_cfg_store
    import gpio_bank_pkg::*;
#(
    parameter int NUM_LINES = 32
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          mask_we,
    input  logic                          cfg_we,
    input  logic [BUS_W-1:0]              wdata,
    output logic [BUS_W-1:0]              mask_q,
    output line_cfg_t [NUM_LINES-1:0]     cfg_q,
    output logic [BUS_W-1:0]              cfg_rd_word
);
    localparam int SEL_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;

    line_cfg_t        new_cfg;
    logic [SEL_W-1:0] rd_sel;
    logic             rd_hit;

    assign new_cfg = cfg_from_word(wdata);

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
        end else if (mask_we) begin
            mask_q <= wdata;
        end
    end

    // one configuration word per line, loaded only when its mask bit is set
    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst) begin
                cfg_q[g] <= '0;
            end else if (cfg_we && mask_q[g]) begin
                cfg_q[g] <= new_cfg;
            end
        end
    end

    // lowest selected line wins the readback
    always_comb begin
        rd_sel = '0;
        rd_hit = 1'b0;
        for (int i = NUM_LINES - 1; i >= 0; i--) begin
            if (mask_q[i]) begin
                rd_sel = SEL_W'(i);
                rd_hit = 1'b1;
            end
        end
    end

    assign cfg_rd_word = rd_hit ? cfg_to_word(cfg_q[rd_sel]) : '0;

endmodule

// File: rtl/gpio_out_latch.sv
module gpio_out_latch #(
    parameter int NUM_LINES = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 set_we,
    input  logic                 clr_we,
    input  logic [NUM_LINES-1:0] bits,
    output logic [NUM_LINES-1:0] latch_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q <= '0;
        end else if (set_we) begin
            latch_q <= latch_q | bits;
        end else if (clr_we) begin
            latch_q <= latch_q & ~bits;
        end
    end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int NUM_LINES = 32,
    parameter int STAGES    = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] d,
    output logic [NUM_LINES-1:0] q
);
    logic [NUM_LINES-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stage_q[s] <= '0;
                else     stage_q[s] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stage_q[s] <= '0;
                else     stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_pad_drive.sv
module gpio_pad_drive
    import gpio_bank_pkg::*;
#(
    parameter int NUM_LINES = 32
) (
    input  line_cfg_t [NUM_LINES-1:0]   cfg,
    input  logic [NUM_LINES-1:0]        latch,
    output logic [NUM_LINES-1:0]        pad_out,
    output logic [NUM_LINES-1:0]        pad_oe,
    output logic [NUM_LINES-1:0][2:0]   pad_func,
    output logic [NUM_LINES-1:0]        pad_pull_up,
    output logic [NUM_LINES-1:0]        pad_pull_dn,
    output logic [NUM_LINES-1:0]        pad_slew,
    output logic [NUM_LINES-1:0]        pad_filt_en,
    output logic [NUM_LINES-1:0]        pad_filt_slow,
    output logic [NUM_LINES-1:0]        pad_open_drain,
    output logic [NUM_LINES-1:0]        pad_schmitt,
    output logic [NUM_LINES-1:0][1:0]   pad_drive
);
    for (genvar g = 0; g < NUM_LINES; g++) begin : g_pad
        logic owned;
        assign owned = (cfg[g].func == 3'd0);

        // open-drain: drive low only, release when latch is 1
        assign pad_out[g] = owned & ~cfg[g].open_drain & latch[g];
        assign pad_oe[g]  = owned & cfg[g].dir & (~cfg[g].open_drain | ~latch[g]);

        assign pad_func[g]       = cfg[g].func;
        assign pad_pull_up[g]    = cfg[g].pull_up;
        assign pad_pull_dn[g]    = cfg[g].pull_dn;
        assign pad_slew[g]       = cfg[g].slew;
        assign pad_filt_en[g]    = cfg[g].filt_en;
        assign pad_filt_slow[g]  = cfg[g].filt_slow;
        assign pad_open_drain[g] = cfg[g].open_drain;
        assign pad_schmitt[g]    = cfg[g].schmitt;
        assign pad_drive[g]      = cfg[g].drive;
    end
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
    import gpio_bank_pkg::*;
#(
    parameter int NUM_LINES   = 32,
    parameter int ADDR_W      = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       bus_wr_en,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic [31:0]                bus_wdata,
    output logic [31:0]                bus_rdata,
    input  logic [NUM_LINES-1:0]       pad_in,
    output logic [NUM_LINES-1:0]       pad_out,
    output logic [NUM_LINES-1:0]       pad_oe,
    output logic [NUM_LINES-1:0][2:0]  pad_func,
    output logic [NUM_LINES-1:0]       pad_pull_up,
    output logic [NUM_LINES-1:0]       pad_pull_dn,
    output logic [NUM_LINES-1:0]       pad_slew,
    output logic [NUM_LINES-1:0]       pad_filt_en,
    output logic [NUM_LINES-1:0]       pad_filt_slow,
    output logic [NUM_LINES-1:0]       pad_open_drain,
    output logic [NUM_LINES-1:0]       pad_schmitt,
    output logic [NUM_LINES-1:0][1:0]  pad_drive
);
    localparam int WA_W = ADDR_W - 2;

    logic [WA_W-1:0]              word_addr;
    logic                         aligned;
    logic                         hit_mask, hit_cfg, hit_pins, hit_set, hit_clr, hit_outs;
    logic [BUS_W-1:0]             mask_q;
    line_cfg_t [NUM_LINES-1:0]    cfg_q;
    logic [BUS_W-1:0]             cfg_rd_word;
    logic [NUM_LINES-1:0]         latch_q;
    logic [NUM_LINES-1:0]         pins_q;

    assign word_addr = bus_addr[ADDR_W-1:2];
    assign aligned   = (bus_addr[1:0] == 2'b00);

    assign hit_mask = aligned && (word_addr == WA_W'(WA_MASK));
    assign hit_cfg  = aligned && (word_addr == WA_W'(WA_CFG));
    assign hit_pins = aligned && (word_addr == WA_W'(WA_PINS));
    assign hit_set  = aligned && (word_addr == WA_W'(WA_SET));
    assign hit_clr  = aligned && (word_addr == WA_W'(WA_CLR));
    assign hit_outs = aligned && (word_addr == WA_W'(WA_OUTS));

    gpio_cfg_store #(.NUM_LINES(NUM_LINES)) u_cfg (
        .clk         (clk),
        .rst         (rst),
        .mask_we     (bus_wr_en && hit_mask),
        .cfg_we      (bus_wr_en && hit_cfg),
        .wdata       (bus_wdata),
        .mask_q      (mask_q),
        .cfg_q       (cfg_q),
        .cfg_rd_word (cfg_rd_word)
    );

    gpio_out_latch #(.NUM_LINES(NUM_LINES)) u_latch (
        .clk     (clk),
        .rst     (rst),
        .set_we  (bus_wr_en && hit_set),
        .clr_we  (bus_wr_en && hit_clr),
        .bits    (bus_wdata[NUM_LINES-1:0]),
        .latch_q (latch_q)
    );

    gpio_in_sync #(.NUM_LINES(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pad_in),
        .q   (pins_q)
    );

    gpio_pad_drive #(.NUM_LINES(NUM_LINES)) u_pad (
        .cfg            (cfg_q),
        .latch          (latch_q),
        .pad_out        (pad_out),
        .pad_oe         (pad_oe),
        .pad_func       (pad_func),
        .pad_pull_up    (pad_pull_up),
        .pad_pull_dn    (pad_pull_dn),
        .pad_slew       (pad_slew),
        .pad_filt_en    (pad_filt_en),
        .pad_filt_slow  (pad_filt_slow),
        .pad_open_drain (pad_open_drain),
        .pad_schmitt    (pad_schmitt),
        .pad_drive      (pad_drive)
    );

    always_comb begin
        bus_rdata = '0;
        if (hit_mask)      bus_rdata = mask_q;
        else if (hit_cfg)  bus_rdata = cfg_rd_word;
        else if (hit_pins) bus_rdata = BUS_W'(pins_q);
        else if (hit_outs) bus_rdata = BUS_W'(latch_q);
    end

endmodule

// File: rtl/gpio_bank_regs_chk.sv
module gpio_bank_regs_chk #(
    parameter int NUM_LINES = 32,
    parameter int ADDR_W    = 6
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      bus_wr_en,
    input logic [ADDR_W-1:0]         bus_addr,
    input logic [31:0]               bus_wdata,
    input logic [31:0]               bus_rdata,
    input logic [NUM_LINES-1:0]      pad_out,
    input logic [NUM_LINES-1:0]      pad_oe,
    input logic [NUM_LINES-1:0][2:0] pad_func,
    input logic [NUM_LINES-1:0]      pad_open_drain,
    input logic [NUM_LINES-1:0]      latch_q,
    input logic [31:0]               mask_q
);
    logic [ADDR_W-1:0]    a_set, a_clr, a_mask;
    logic                 wr_set, wr_clr, wr_mask;
    logic                 unmapped;
    logic [NUM_LINES-1:0] periph;
    logic [NUM_LINES-1:0] wbits;

    assign a_mask  = ADDR_W'(8'h00);
    assign a_set   = ADDR_W'(8'h10);
    assign a_clr   = ADDR_W'(8'h14);
    assign wr_mask = bus_wr_en && (bus_addr == a_mask);
    assign wr_set  = bus_wr_en && (bus_addr == a_set);
    assign wr_clr  = bus_wr_en && (bus_addr == a_clr);
    assign wbits   = bus_wdata[NUM_LINES-1:0];

    assign unmapped = (bus_addr[1:0] != 2'b00) || (bus_addr == ADDR_W'(8'h0C)) ||
                      (bus_addr == a_set) || (bus_addr == a_clr) ||
                      (bus_addr >= ADDR_W'(8'h1C));

    always_comb begin
        for (int i = 0; i < NUM_LINES; i++) periph[i] = (pad_func[i] != 3'd0);
    end

    a_r1_reset_quiet: assert property (@(posedge clk) rst |=> (pad_oe == '0 && latch_q == '0));

    a_r2_mask_store: assert property (@(posedge clk) disable iff (rst)
        wr_mask |=> mask_q == $past(bus_wdata));

    a_r5_set_bits: assert property (@(posedge clk) disable iff (rst)
        wr_set |=> (latch_q & $past(wbits)) == $past(wbits)
                   && (latch_q & ~$past(wbits)) == ($past(latch_q) & ~$past(wbits)));

    a_r6_clear_bits: assert property (@(posedge clk) disable iff (rst)
        wr_clr |=> (latch_q & $past(wbits)) == '0
                   && (latch_q & ~$past(wbits)) == ($past(latch_q) & ~$past(wbits)));

    a_r13_latch_hold: assert property (@(posedge clk) disable iff (rst)
        !(wr_set || wr_clr) |=> $stable(latch_q));

    a_r10_open_drain_low: assert property (@(posedge clk) disable iff (rst)
        ((pad_oe & pad_open_drain & latch_q) == '0) && ((pad_out & pad_open_drain) == '0));

    a_r11_periph_released: assert property (@(posedge clk) disable iff (rst)
        ((pad_oe & periph) == '0) && ((pad_out & periph) == '0));

    a_r13_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
        unmapped |-> bus_rdata == 32'h0);

endmodule

bind gpio_bank_regs gpio_bank_regs_chk #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .bus_wr_en      (bus_wr_en),
    .bus_addr       (bus_addr),
    .bus_wdata      (bus_wdata),
    .bus_rdata      (bus_rdata),
    .pad_out        (pad_out),
    .pad_oe         (pad_oe),
    .pad_func       (pad_func),
    .pad_open_drain (pad_open_drain),
    .latch_q        (latch_q),
    .mask_q         (mask_q)
);

// File: tb/test_gpio_bank_regs.sv
module test_gpio_bank_regs;
    localparam int N  = 32;
    localparam int AW = 6;
    localparam logic [31:0] FIELDS = 32'h0703_FF07;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               bus_wr_en = 1'b0;
    logic [AW-1:0]      bus_addr = '0;
    logic [31:0]        bus_wdata = '0;
    logic [31:0]        bus_rdata;
    logic [N-1:0]       pad_in = '0;
    logic [N-1:0]       pad_out, pad_oe;
    logic [N-1:0][2:0]  pad_func;
    logic [N-1:0]       pad_pull_up, pad_pull_dn, pad_slew, pad_filt_en;
    logic [N-1:0]       pad_filt_slow, pad_open_drain, pad_schmitt;
    logic [N-1:0][1:0]  pad_drive;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #5 clk = ~clk;

    gpio_bank_regs #(.NUM_LINES(N), .ADDR_W(AW), .SYNC_STAGES(2)) i_gpio_bank_regs (
        .clk(clk), .rst(rst), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_func(pad_func),
        .pad_pull_up(pad_pull_up), .pad_pull_dn(pad_pull_dn), .pad_slew(pad_slew),
        .pad_filt_en(pad_filt_en), .pad_filt_slow(pad_filt_slow),
        .pad_open_drain(pad_open_drain), .pad_schmitt(pad_schmitt), .pad_drive(pad_drive)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr_en = 1'b1; bus_addr = AW'(a); bus_wdata = d;
        @(negedge clk);
        bus_wr_en = 1'b0; bus_wdata = '0;
        #1;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = AW'(a);
        #1;
        d = bus_rdata;
    endtask

    function automatic logic [31:0] pattern(input int i);
        return (32'(i) * 32'h0105_2083) ^ 32'h5A3C_96E1;
    endfunction

    // pad field view of one line packed like the configuration word
    function automatic logic [31:0] pad_view(input int i);
        logic [31:0] w;
        w = '0;
        w[2:0]   = pad_func[i];
        w[9]     = pad_pull_up[i];
        w[10]    = pad_pull_dn[i];
        w[11]    = pad_slew[i];
        w[12]    = pad_filt_en[i];
        w[13]    = pad_filt_slow[i];
        w[14]    = pad_open_drain[i];
        w[15]    = pad_schmitt[i];
        w[17:16] = pad_drive[i];
        return w;
    endfunction

    localparam logic [31:0] PAD_FIELDS = 32'h0003_FE07;

    initial begin
        logic [31:0] d, exp_latch, exp_cfg, grp, v_old, v_new;
        logic [31:0] cfg_img [N];

        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1 reset state
        for (int a = 0; a < 8; a++) begin
            rd(8'(a * 4), d);
            check("R1 reset readback", d, 32'h0);
        end
        check("R1 reset pad_oe", 32'(pad_oe), 32'h0);
        for (int i = 0; i < N; i++) check("R12 reset drive", 32'(pad_drive[i]), 32'h0);

        // R2 mask readback
        foreach (grp[k]) begin end
        for (int k = 0; k < 6; k++) begin
            v_new = pattern(k * 7 + 1);
            wr(8'h00, v_new);
            rd(8'h00, d);
            check("R2 mask readback", d, v_new);
        end

        // R3/R4/R12 one-hot sweep over all lines
        for (int i = 0; i < N; i++) begin
            wr(8'h00, 32'h1 << i);
            wr(8'h04, pattern(i));
            cfg_img[i] = pattern(i) & FIELDS;
        end
        for (int i = 0; i < N; i++) begin
            wr(8'h00, 32'h1 << i);
            rd(8'h04, d);
            check("R4 single line readback", d, cfg_img[i]);
            check("R12 pad fields", pad_view(i), cfg_img[i] & PAD_FIELDS);
        end

        // R3 multi-line write reaches only selected lines
        grp = 32'h00F0_F00F;
        wr(8'h00, grp);
        wr(8'h04, 32'hFFFF_FFFF ^ 32'h0402_4105);
        for (int i = 0; i < N; i++)
            if (grp[i]) cfg_img[i] = (32'hFFFF_FFFF ^ 32'h0402_4105) & FIELDS;
        for (int i = 0; i < N; i++) begin
            wr(8'h00, 32'h1 << i);
            rd(8'h04, d);
            check("R3 masked write scope", d, cfg_img[i]);
        end

        // R4 lowest selected line wins
        wr(8'h00, (32'h1 << 5) | (32'h1 << 17));
        rd(8'h04, d);
        check("R4 lowest line 5", d, cfg_img[5]);
        wr(8'h00, (32'h1 << 31) | (32'h1 << 20) | (32'h1 << 12));
        rd(8'h04, d);
        check("R4 lowest line 12", d, cfg_img[12]);
        wr(8'h00, 32'h0);
        rd(8'h04, d);
        check("R4 empty mask reads zero", d, 32'h0);

        // R3 empty mask write changes nothing
        wr(8'h04, 32'h0000_0000);
        for (int i = 0; i < N; i += 7) begin
            wr(8'h00, 32'h1 << i);
            rd(8'h04, d);
            check("R3 empty mask write ignored", d, cfg_img[i]);
        end

        // R5/R6/R7 latch set and clear
        exp_latch = '0;
        for (int k = 0; k < 16; k++) begin
            v_new = 32'(k + 1) * 32'h9E37_79B9;
            if (k % 2 == 0) begin
                wr(8'h10, v_new);
                exp_latch = exp_latch | v_new;
                rd(8'h18, d);
                check("R5 set bits", d, exp_latch);
            end else begin
                wr(8'h14, v_new);
                exp_latch = exp_latch & ~v_new;
                rd(8'h18, d);
                check("R6 clear bits", d, exp_latch);
            end
        end
        wr(8'h10, 32'h0);
        rd(8'h18, d);
        check("R5 zero set no effect", d, exp_latch);
        wr(8'h14, 32'h0);
        rd(8'h18, d);
        check("R6 zero clear no effect", d, exp_latch);
        wr(8'h14, 32'hFFFF_FFFF);
        rd(8'h18, d);
        check("R7 latch all clear", d, 32'h0);
        exp_latch = '0;

        // R9/R10/R11 pad drive sweep on line 3
        wr(8'h00, 32'h1 << 3);
        for (int f = 0; f < 8; f++)
            for (int dir = 0; dir < 2; dir++)
                for (int od = 0; od < 2; od++)
                    for (int lv = 0; lv < 2; lv++) begin
                        logic e_oe, e_out;
                        exp_cfg = 32'(f) | (32'(dir) << 8) | (32'(od) << 14);
                        wr(8'h04, exp_cfg);
                        if (lv == 1) wr(8'h10, 32'h8); else wr(8'h14, 32'h8);
                        if (f != 0) begin
                            e_oe = 1'b0; e_out = 1'b0;
                            check("R11 periph oe", 32'(pad_oe[3]), 32'(e_oe));
                            check("R11 periph out", 32'(pad_out[3]), 32'(e_out));
                        end else if (od == 1) begin
                            e_oe = dir[0] & ~lv[0]; e_out = 1'b0;
                            check("R10 open-drain oe", 32'(pad_oe[3]), 32'(e_oe));
                            check("R10 open-drain out", 32'(pad_out[3]), 32'(e_out));
                        end else begin
                            e_oe = dir[0]; e_out = lv[0];
                            check("R9 push-pull oe", 32'(pad_oe[3]), 32'(e_oe));
                            check("R9 push-pull out", 32'(pad_out[3]), 32'(e_out));
                        end
                    end

        // R8 two-stage pin synchronizer
        v_old = '0;
        for (int k = 0; k < 8; k++) begin
            v_new = pattern(k + 40) ^ 32'(k);
            @(negedge clk);
            bus_addr = AW'(8'h08);
            pad_in = v_new;
            #1 check("R8 no same-cycle pass", bus_rdata, v_old);
            @(negedge clk);
            #1 check("R8 one edge not enough", bus_rdata, v_old);
            @(negedge clk);
            #1 check("R8 visible after two edges", bus_rdata, v_new);
            v_old = v_new;
        end

        // R13 unmapped and read-only offsets
        wr(8'h10, 32'h1234_5678);
        exp_latch = 32'h1234_5678;
        wr(8'h00, 32'h0000_0C00);
        rd(8'h0C, d); check("R13 lock offset zero", d, 32'h0);
        rd(8'h10, d); check("R13 set offset reads zero", d, 32'h0);
        rd(8'h14, d); check("R13 clear offset reads zero", d, 32'h0);
        rd(8'h1C, d); check("R13 offset 0x1C zero", d, 32'h0);
        rd(8'h3C, d); check("R13 offset 0x3C zero", d, 32'h0);
        rd(8'h02, d); check("R13 unaligned zero", d, 32'h0);
        wr(8'h18, 32'hFFFF_FFFF);
        wr(8'h08, 32'hFFFF_FFFF);
        wr(8'h0C, 32'hFFFF_FFFF);
        wr(8'h3C, 32'hFFFF_FFFF);
        wr(8'h11, 32'hFFFF_FFFF);
        wr(8'h01, 32'hFFFF_FFFF);
        rd(8'h18, d); check("R13 write to read-only keeps latch", d, exp_latch);
        rd(8'h00, d); check("R13 write to unmapped keeps mask", d, 32'h0000_0C00);
        rd(8'h04, d); check("R13 config untouched", d, cfg_img[10]);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule